// File: doc/BRIEF.md
# DMA channel start arbiter

This block decides which channel of a multi-channel DMA engine starts next, and it tracks the one channel that is executing. Each channel raises a service request. The request is held pending until that channel is granted. When no channel is active and starting is allowed, the unit picks one pending channel, either by lowest index or round robin, and issues a one-cycle start pulse that carries the channel index. The channel then counts as active until the transfer datapath reports the end of its minor loop.

The host sets the policy with level and pulse controls:

- **Halt flag.** A software halt stops new starts. A halt raised automatically on an error, when halt-on-error is enabled, also drops any incoming requests.
- **Debug stall.** The external debug input holds off new starts when debug is enabled.
- **Continuous link.** A channel whose minor loop links to itself restarts at once, without arbitration.
- **Error cancel.** This command ends the running channel after its current read/write pair and records the cancel as an error.

An error record holds the channel number and a valid flag. It drives an interrupt output that the host can mask.

Top module: `dma_start_arb`

## Requirements
- R1: With `rr_mode_i`=0, the pending channel with the lowest index is granted.
- R2: With `rr_mode_i`=1, the search starts at a pointer and scans upward, wrapping from N_CH-1 to 0. After each grant the pointer becomes (granted index + 1) mod N_CH. The pointer is 0 after reset.
- R3: At most one channel is active. `start_o` is high for one cycle, two clock edges after the request pulse when the unit is idle, and `start_ch_o` carries the granted index. No grant is issued while a channel is active. A channel stops being active on the edge that samples `rw_done_i` and `loop_done_i` both high.
- R4: While `halt_o`=1, no new channel starts, but the active channel continues until it is done. Requests stay pending, and starting resumes after `halt_clr_i`. `halt_set_i` sets `halt_o` on the next edge.
- R5: If `hoe_i`=1, any error event (`err_i` or an honoured cancel) sets `halt_o` on the next edge. Requests that arrive while the halt came from an error are dropped and never start.
- R6: With `dbg_en_i`=1 and `dbg_i`=1, no new channel starts. Starting resumes when either signal falls. With `dbg_en_i`=0, `dbg_i` has no effect.
- R7: With `cont_link_i`=1, finishing a minor loop with `self_link_i`=1 produces a start pulse for the same channel on the very next edge, with no idle cycle. With `cont_link_i`=0, the channel is made pending again and competes through normal arbitration.
- R8: `ecx_set_i` while a channel is active sets `ecx_o`. The cancel waits for the next `rw_done_i`. On that edge `cancel_o` pulses for one cycle, the channel becomes inactive and `ecx_o` clears. `ecx_set_i` while idle is ignored.
- R9: An error event sets `err_vld_o` and loads `err_ch_o`. For `err_i` the channel is `err_ch_i`; for a cancel it is the cancelled channel. `err_irq_o` = `err_vld_o` AND `err_int_en_i`. `err_clr_i` clears the valid flag, and a new error in the same cycle wins.
- R10: A single-cycle request pulse is remembered until its channel is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_CH | Per-channel service request |
| rr_mode_i | input | 1 | 0 fixed priority, 1 round robin |
| halt_set_i | input | 1 | Pulse: set halt |
| halt_clr_i | input | 1 | Pulse: clear halt |
| hoe_i | input | 1 | Halt on error enable |
| dbg_en_i | input | 1 | Debug stall enable |
| dbg_i | input | 1 | External debug request |
| cont_link_i | input | 1 | Continuous self-link mode |
| ecx_set_i | input | 1 | Pulse: request error cancel |
| rw_done_i | input | 1 | End of one read/write pair |
| loop_done_i | input | 1 | Minor loop complete (with rw_done_i) |
| self_link_i | input | 1 | Active channel's minor link targets itself |
| err_i | input | 1 | Transfer error event |
| err_ch_i | input | CH_W | Channel of the transfer error |
| err_clr_i | input | 1 | Pulse: clear error valid |
| err_int_en_i | input | 1 | Error interrupt enable |
| start_o | output | 1 | One-cycle channel start |
| start_ch_o | output | CH_W | Started channel |
| active_o | output | 1 | A channel is executing |
| active_ch_o | output | CH_W | Executing channel |
| cancel_o | output | 1 | One-cycle forced minor-loop finish |
| halt_o | output | 1 | Halt state |
| ecx_o | output | 1 | Error cancel pending |
| err_vld_o | output | 1 | Error record valid |
| err_ch_o | output | CH_W | Channel of last error |
| err_irq_o | output | 1 | Error interrupt |

## Verification
Arbitration is driven with sparse masks, adjacent low channels and a full mask. The same kind of mask is applied in fixed mode and in round-robin mode, so the grant order exposes both the lowest-index rule and the pointer advance with wrap-around. The stall sources are tried separately: software halt, error-driven halt, and debug with and without its enable. Each case checks whether a request is held or dropped and whether the running channel still finishes. The self-link is run with continuous mode on and off, with a competing lower channel pending, so that a direct restart is told apart from one that goes back through arbitration. The cancel is held across several idle cycles before the read/write pair ends, which confirms it waits for that pair and is then logged as an error.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  function automatic int unsigned ch_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int unsigned N_CH = 8,
  parameter int unsigned CH_W = 3
) (
  input  logic [N_CH-1:0] pend_i,
  input  logic [CH_W-1:0] ptr_i,
  input  logic            rr_i,
  output logic            any_o,
  output logic [CH_W-1:0] idx_o
);
  logic [CH_W-1:0] fix_idx, rr_idx;
  int j;

  always_comb begin
    fix_idx = '0;
    for (int i = N_CH - 1; i >= 0; i--)
      if (pend_i[i]) fix_idx = CH_W'(i);
  end

  // scan upward from ptr, wrapping
  always_comb begin
    rr_idx = '0;
    j = 0;
    for (int k = N_CH - 1; k >= 0; k--) begin
      j = int'(ptr_i) + k;
      if (j >= int'(N_CH)) j = j - int'(N_CH);
      if (pend_i[j]) rr_idx = CH_W'(j);
    end
  end

  assign any_o = |pend_i;
  assign idx_o = rr_i ? rr_idx : fix_idx;
endmodule

// File: rtl/dma_arb_ctl.sv
module dma_arb_ctl #(
  parameter int unsigned CH_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            halt_set_i,
  input  logic            halt_clr_i,
  input  logic            hoe_i,
  input  logic            ecx_set_i,
  input  logic            active_i,
  input  logic [CH_W-1:0] active_ch_i,
  input  logic            rw_done_i,
  input  logic            err_i,
  input  logic [CH_W-1:0] err_ch_i,
  input  logic            err_clr_i,
  input  logic            err_int_en_i,
  output logic            halt_o,
  output logic            halt_err_o,
  output logic            ecx_o,
  output logic            cancel_now_o,
  output logic            err_vld_o,
  output logic [CH_W-1:0] err_ch_o,
  output logic            err_irq_o
);
  logic            halt_q, halt_err_q, ecx_q, err_vld_q;
  logic [CH_W-1:0] err_ch_q;
  logic            cancel_now, err_evt, hoe_trip;

  assign cancel_now = ecx_q & active_i & rw_done_i;
  assign err_evt    = err_i | cancel_now;
  assign hoe_trip   = hoe_i & err_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_q     <= 1'b0;
      halt_err_q <= 1'b0;
    end else if (halt_set_i || hoe_trip) begin
      halt_q     <= 1'b1;
      halt_err_q <= halt_err_q | hoe_trip;
    end else if (halt_clr_i) begin
      halt_q     <= 1'b0;
      halt_err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ecx_q <= 1'b0;
    else if (cancel_now) ecx_q <= 1'b0;
    else if (ecx_set_i && active_i) ecx_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_vld_q <= 1'b0;
      err_ch_q  <= '0;
    end else if (err_evt) begin
      err_vld_q <= 1'b1;
      err_ch_q  <= err_i ? err_ch_i : active_ch_i;
    end else if (err_clr_i) begin
      err_vld_q <= 1'b0;
    end
  end

  assign halt_o       = halt_q;
  assign halt_err_o   = halt_err_q;
  assign ecx_o        = ecx_q;
  assign cancel_now_o = cancel_now;
  assign err_vld_o    = err_vld_q;
  assign err_ch_o     = err_ch_q;
  assign err_irq_o    = err_vld_q & err_int_en_i;

  p_hoe_halt_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hoe_i && err_i) |=> halt_q);
  p_ecx_wait_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ecx_q && !rw_done_i) |=> ecx_q);
  p_err_log_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_evt |=> err_vld_q);
endmodule

// File: rtl/dma_start_arb.sv
module dma_start_arb #(
  parameter int unsigned N_CH = 8,
  parameter int unsigned CH_W = dma_arb_pkg::ch_bits(N_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] req_i,
  input  logic            rr_mode_i,
  input  logic            halt_set_i,
  input  logic            halt_clr_i,
  input  logic            hoe_i,
  input  logic            dbg_en_i,
  input  logic            dbg_i,
  input  logic            cont_link_i,
  input  logic            ecx_set_i,
  input  logic            rw_done_i,
  input  logic            loop_done_i,
  input  logic            self_link_i,
  input  logic            err_i,
  input  logic [CH_W-1:0] err_ch_i,
  input  logic            err_clr_i,
  input  logic            err_int_en_i,
  output logic            start_o,
  output logic [CH_W-1:0] start_ch_o,
  output logic            active_o,
  output logic [CH_W-1:0] active_ch_o,
  output logic            cancel_o,
  output logic            halt_o,
  output logic            ecx_o,
  output logic            err_vld_o,
  output logic [CH_W-1:0] err_ch_o,
  output logic            err_irq_o
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(N_CH - 1);

  logic [N_CH-1:0] pend_q, acc, relink_oh;
  logic [CH_W-1:0] ptr_q, pick_idx, active_ch_q, start_ch_q;
  logic            active_q, start_q, cancel_q;
  logic            pick_any, halt, halt_err, cancel_now;
  logic            stall, grant, loop_end, ch_end, restart, relink;

  dma_arb_pick #(.N_CH(N_CH), .CH_W(CH_W)) i_pick (
    .pend_i (pend_q),
    .ptr_i  (ptr_q),
    .rr_i   (rr_mode_i),
    .any_o  (pick_any),
    .idx_o  (pick_idx)
  );

  dma_arb_ctl #(.CH_W(CH_W)) i_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .halt_set_i   (halt_set_i),
    .halt_clr_i   (halt_clr_i),
    .hoe_i        (hoe_i),
    .ecx_set_i    (ecx_set_i),
    .active_i     (active_q),
    .active_ch_i  (active_ch_q),
    .rw_done_i    (rw_done_i),
    .err_i        (err_i),
    .err_ch_i     (err_ch_i),
    .err_clr_i    (err_clr_i),
    .err_int_en_i (err_int_en_i),
    .halt_o       (halt),
    .halt_err_o   (halt_err),
    .ecx_o        (ecx_o),
    .cancel_now_o (cancel_now),
    .err_vld_o    (err_vld_o),
    .err_ch_o     (err_ch_o),
    .err_irq_o    (err_irq_o)
  );

  assign stall    = halt | (dbg_en_i & dbg_i);
  assign grant    = ~active_q & ~stall & pick_any;
  assign loop_end = active_q & rw_done_i & loop_done_i & ~cancel_now;
  assign ch_end   = loop_end | cancel_now;
  assign restart  = loop_end & self_link_i & cont_link_i;
  assign relink   = loop_end & self_link_i & ~cont_link_i;

  // requests are dropped while halted by an error
  assign acc       = req_i & {N_CH{~halt_err}};
  assign relink_oh = (relink && !halt_err) ? (N_CH'(1) << active_ch_q) : '0;

  for (genvar c = 0; c < N_CH; c++) begin : g_pend
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  pend_q[c] <= 1'b0;
      else if (grant && pick_idx == CH_W'(c))       pend_q[c] <= 1'b0;
      else if (acc[c] || relink_oh[c])              pend_q[c] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q    <= 1'b0;
      active_ch_q <= '0;
    end else if (grant) begin
      active_q    <= 1'b1;
      active_ch_q <= pick_idx;
    end else if (ch_end && !restart) begin
      active_q    <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q    <= 1'b0;
      start_ch_q <= '0;
      cancel_q   <= 1'b0;
    end else begin
      start_q    <= grant | restart;
      start_ch_q <= grant ? pick_idx : active_ch_q;
      cancel_q   <= cancel_now;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (grant) ptr_q <= (pick_idx == LAST_CH) ? '0 : pick_idx + 1'b1;
  end

  assign start_o     = start_q;
  assign start_ch_o  = start_ch_q;
  assign active_o    = active_q;
  assign active_ch_o = active_ch_q;
  assign cancel_o    = cancel_q;
  assign halt_o      = halt;

  p_start_active_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> active_q);
  p_no_grant_busy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !(rw_done_i && loop_done_i)) |=> !start_q);
  p_halt_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt && !active_q) |=> !start_q);
  p_dbg_stall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbg_en_i && dbg_i && !active_q) |=> !start_q);
  p_cont_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (start_q && active_q && start_ch_q == $past(active_ch_q)));
  p_cancel_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_q |-> !active_q);
endmodule

// File: tb/test_dma_start_arb.sv
module test_dma_start_arb;
  localparam int N_CH = 8;
  localparam int CH_W = 3;

  typedef struct packed {
    logic        rr;
    logic [7:0]  mask;
    logic [3:0]  n;
    logic [23:0] seq;
  } vec_t;

  // expected grant order, entry i at seq[3*i +: 3]
  localparam vec_t VEC [5] = '{
    '{1'b0, 8'hA4, 4'd3, {15'd0, 3'd7, 3'd5, 3'd2}},
    '{1'b0, 8'h03, 4'd2, {18'd0, 3'd1, 3'd0}},
    '{1'b1, 8'h07, 4'd3, {15'd0, 3'd1, 3'd0, 3'd2}},
    '{1'b1, 8'h82, 4'd2, {18'd0, 3'd1, 3'd7}},
    '{1'b1, 8'hFF, 4'd8, {3'd1, 3'd0, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2}}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [N_CH-1:0] req_i = '0;
  logic rr_mode_i = 0, halt_set_i = 0, halt_clr_i = 0, hoe_i = 0;
  logic dbg_en_i = 0, dbg_i = 0, cont_link_i = 0, ecx_set_i = 0;
  logic rw_done_i = 0, loop_done_i = 0, self_link_i = 0, err_i = 0;
  logic [CH_W-1:0] err_ch_i = '0;
  logic err_clr_i = 0, err_int_en_i = 0;
  logic start_o, active_o, cancel_o, halt_o, ecx_o, err_vld_o, err_irq_o;
  logic [CH_W-1:0] start_ch_o, active_ch_o, err_ch_o;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  dma_start_arb #(.N_CH(N_CH)) i_dma_start_arb (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .rr_mode_i(rr_mode_i),
    .halt_set_i(halt_set_i), .halt_clr_i(halt_clr_i), .hoe_i(hoe_i),
    .dbg_en_i(dbg_en_i), .dbg_i(dbg_i), .cont_link_i(cont_link_i),
    .ecx_set_i(ecx_set_i), .rw_done_i(rw_done_i), .loop_done_i(loop_done_i),
    .self_link_i(self_link_i), .err_i(err_i), .err_ch_i(err_ch_i),
    .err_clr_i(err_clr_i), .err_int_en_i(err_int_en_i),
    .start_o(start_o), .start_ch_o(start_ch_o), .active_o(active_o),
    .active_ch_o(active_ch_o), .cancel_o(cancel_o), .halt_o(halt_o),
    .ecx_o(ecx_o), .err_vld_o(err_vld_o), .err_ch_o(err_ch_o),
    .err_irq_o(err_irq_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_req(input logic [N_CH-1:0] m);
    req_i = m;
    @(negedge clk);
    req_i = '0;
  endtask

  task automatic expect_start(input int ch, input string tag);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (start_o) break;
    end
    chk({tag, " start"}, int'(start_o), 1);
    chk({tag, " channel"}, int'(start_ch_o), ch);
  endtask

  task automatic finish_ch(input logic sl);
    rw_done_i = 1; loop_done_i = 1; self_link_i = sl;
    @(negedge clk);
    rw_done_i = 0; loop_done_i = 0; self_link_i = 0;
  endtask

  task automatic expect_quiet(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (start_o) seen++;
    end
    chk({tag, " no start"}, seen, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R3 reset start", int'(start_o), 0);
    chk("R3 reset active", int'(active_o), 0);
    chk("R4 reset halt", int'(halt_o), 0);
    chk("R9 reset err_vld", int'(err_vld_o), 0);
    rst_ni = 1;
    @(negedge clk);

    // R1 / R2 / R10 vector walk
    foreach (VEC[v]) begin
      rr_mode_i = VEC[v].rr;
      pulse_req(VEC[v].mask);
      for (int k = 0; k < int'(VEC[v].n); k++) begin
        expect_start(int'(VEC[v].seq[3*k +: 3]), VEC[v].rr ? "R2 rr order" : "R1 fixed order");
        chk("R3 active during run", int'(active_o), 1);
        finish_ch(1'b0);
      end
      chk("R3 idle after vector", int'(active_o), 0);
    end
    rr_mode_i = 0;

    // R3 start pulse lasts one cycle, timing from request
    req_i = 8'h10;
    @(negedge clk);
    req_i = '0;
    chk("R3 no start after one edge", int'(start_o), 0);
    @(negedge clk);
    chk("R3 start after two edges", int'(start_o), 1);
    chk("R3 start index", int'(start_ch_o), 4);
    @(negedge clk);
    chk("R3 start one cycle", int'(start_o), 0);
    finish_ch(1'b0);

    // R4 halt: running channel continues, requests held
    pulse_req(8'h04);
    expect_start(2, "R4 pre");
    halt_set_i = 1; @(negedge clk); halt_set_i = 0;
    chk("R4 halt set", int'(halt_o), 1);
    chk("R4 active kept", int'(active_o), 1);
    pulse_req(8'h10);
    finish_ch(1'b0);
    chk("R4 active done", int'(active_o), 0);
    expect_quiet(8, "R4 halted");
    halt_clr_i = 1; @(negedge clk); halt_clr_i = 0;
    expect_start(4, "R4 resume R10");
    finish_ch(1'b0);

    // R6 debug stall
    dbg_en_i = 1; dbg_i = 1;
    pulse_req(8'h10);
    expect_quiet(8, "R6 dbg stall");
    dbg_i = 0;
    expect_start(4, "R6 dbg release");
    finish_ch(1'b0);
    dbg_en_i = 0; dbg_i = 1;
    pulse_req(8'h40);
    expect_start(6, "R6 dbg ignored");
    finish_ch(1'b0);
    dbg_i = 0;

    // R7 continuous self-link
    cont_link_i = 1;
    pulse_req(8'h08);
    expect_start(3, "R7 cont first");
    finish_ch(1'b1);
    chk("R7 cont immediate start", int'(start_o), 1);
    chk("R7 cont same channel", int'(start_ch_o), 3);
    chk("R7 cont active", int'(active_o), 1);
    finish_ch(1'b0);
    cont_link_i = 0;
    pulse_req(8'h08);
    expect_start(3, "R7 arb first");
    pulse_req(8'h02);
    finish_ch(1'b1);
    chk("R7 no direct restart", int'(start_o), 0);
    expect_start(1, "R7 relink arbitrated");
    finish_ch(1'b0);
    expect_start(3, "R7 relink served");
    finish_ch(1'b0);

    // R8 / R9 error cancel
    err_int_en_i = 1;
    pulse_req(8'h04);
    expect_start(2, "R8 pre");
    ecx_set_i = 1; @(negedge clk); ecx_set_i = 0;
    chk("R8 ecx set", int'(ecx_o), 1);
    repeat (3) @(negedge clk);
    chk("R8 waits active", int'(active_o), 1);
    chk("R8 waits no cancel", int'(cancel_o), 0);
    rw_done_i = 1; @(negedge clk); rw_done_i = 0;
    chk("R8 cancel pulse", int'(cancel_o), 1);
    chk("R8 inactive", int'(active_o), 0);
    chk("R8 ecx self clear", int'(ecx_o), 0);
    chk("R9 cancel logged", int'(err_vld_o), 1);
    chk("R9 cancel channel", int'(err_ch_o), 2);
    chk("R9 irq enabled", int'(err_irq_o), 1);
    @(negedge clk);
    chk("R8 cancel one cycle", int'(cancel_o), 0);
    err_clr_i = 1; @(negedge clk); err_clr_i = 0;
    chk("R9 err clear", int'(err_vld_o), 0);
    chk("R9 irq clear", int'(err_irq_o), 0);
    ecx_set_i = 1; @(negedge clk); ecx_set_i = 0;
    chk("R8 idle ecx ignored", int'(ecx_o), 0);

    // R5 halt on error, drop requests
    hoe_i = 1; err_int_en_i = 0;
    err_ch_i = 3'd6; err_i = 1; @(negedge clk); err_i = 0;
    chk("R5 halt on error", int'(halt_o), 1);
    chk("R9 err valid", int'(err_vld_o), 1);
    chk("R9 err channel", int'(err_ch_o), 6);
    chk("R9 irq masked", int'(err_irq_o), 0);
    pulse_req(8'h20);
    halt_clr_i = 1; @(negedge clk); halt_clr_i = 0;
    chk("R5 halt cleared", int'(halt_o), 0);
    expect_quiet(10, "R5 request dropped");
    pulse_req(8'h20);
    expect_start(5, "R5 after clear");
    finish_ch(1'b0);
    hoe_i = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule